// File: doc/BRIEF.md
# Serial-Bus Write Receiver for a 16-bit Converter Word

This block is the receive side of a two-wire serial bus (I2C) for a 16-bit digital-to-analog converter. It watches the clock and data lines, oversampled by a faster system clock. It recognises start, repeated-start and stop conditions and checks the first byte after each start. When that byte is a high-speed master code (`00001xxx`), the block enters high-speed tracking without acknowledging it. When the byte is its own write address, it accepts a control byte followed by any number of high/low data byte pairs.

Each accepted byte is acknowledged by pulling the data line low during the ninth clock. When the clock falls at the end of the acknowledge for a low data byte, the block does three things in the same cycle:

- it loads the 16-bit word from the pair;
- it copies the control byte of that transaction to its control output;
- it raises a one-cycle update strobe.

A stop returns the receiver to idle and ends high-speed tracking. The loaded word and control byte stay as they were.

Top module: `dac_word_i2c_rx`

## Requirements
- R1: After reset, `sda_pull_o`, `load_pulse_o` and `hs_active_o` are 0, and `word_o` and `ctrl_o` are 0.
- R2: A first byte equal to `{ADDR_HI, a_sel_i, 0}` is acknowledged. `sda_pull_o` is 1 while SCL is high in the ninth clock, and 0 outside acknowledge slots. With the default `ADDR_HI` = 100110, this byte is 0x98 when `a_sel_i` is 0 and 0x9A when it is 1.
- R3: A first byte whose upper five bits are 00001 is not acknowledged, and it sets `hs_active_o` to 1.
- R4: `hs_active_o` stays 1 through a repeated start and clears to 0 on a stop.
- R5: A first byte that does not match the address, or that has bit 0 (read/write) at 1, is not acknowledged. No later byte is acknowledged until the next start.
- R6: After a matched address, the control byte, the high data byte and the low data byte are each acknowledged.
- R7: `load_pulse_o` is a single-cycle pulse. It occurs after the SCL fall that ends the low byte's acknowledge, not before. In that cycle `word_o` = {high byte, low byte} and `ctrl_o` is the transaction's control byte.
- R8: Further high/low pairs that follow without a new control byte each produce their own pulse and word.
- R9: A stop, or an incomplete pair, leaves `word_o` and `ctrl_o` unchanged and gives no pulse.
- R10: After a repeated start, the next byte is evaluated as an address byte, not as data.
- R11: `a_sel_i` supplies address bit 1 of the address byte, and the block answers only the address that matches its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| a_sel_i | input | 1 | Strap setting address bit 1 |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge) |
| word_o | output | 16 | Last loaded converter word |
| ctrl_o | output | 8 | Control byte that came with the last load |
| load_pulse_o | output | 1 | One-cycle update strobe |
| hs_active_o | output | 1 | High-speed master code seen, until stop |

## Verification
The bench sweeps all 256 first-byte values with the address strap at both levels. A decoder that ignored the read/write bit, mis-placed the strap bit or acknowledged a master code would answer the wrong bytes, and a missing stop clear would leave high-speed tracking stuck. Directed sequences stream several pairs after one control byte, stop after a lone high byte, and issue a repeated start in the middle of a data phase. A receiver that committed early, needed a fresh control byte, or took the post-restart byte as data would show a wrong word, a missing or extra strobe, or a stray acknowledge. The bench also records the strobe count at the acknowledge sample, which catches an update fired before the closing clock fall.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;

    localparam int BYTE_W = 8;
    localparam int SLOT_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CTRL,
        PH_HIGH,
        PH_LOW,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        phase_t              phase;
        logic [SLOT_W-1:0]   slot;
        logic [BYTE_W-1:0]   shreg;
        logic                ack;
        logic                hs;
        logic [BYTE_W-1:0]   ctrl_pend;
        logic [BYTE_W-1:0]   hi;
        logic [2*BYTE_W-1:0] word;
        logic [BYTE_W-1:0]   ctrl;
        logic                upd;
    } frame_t;

endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    for (genvar b = 0; b < W; b++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/dacrx_events.sv
module dacrx_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d   = scl_s;
        sda_d   = sda_s;
        start_o = scl_s & scl_q & sda_q & ~sda_s;
        stop_o  = scl_s & scl_q & ~sda_q & sda_s;
        rise_o  = scl_s & ~scl_q;
        fall_o  = ~scl_s & scl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end
endmodule

// File: rtl/dacrx_frame.sv
module dacrx_frame
    import dacrx_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b100110,
    parameter logic [4:0] MCODE   = 5'b00001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stop_i,
    input  logic                rise_i,
    input  logic                fall_i,
    input  logic                sda_s,
    input  logic                a_sel_i,
    output logic                ack_o,
    output logic                hs_o,
    output logic [2*BYTE_W-1:0] word_o,
    output logic [BYTE_W-1:0]   ctrl_o,
    output logic                upd_o
);
    localparam logic [SLOT_W-1:0] LAST_BIT = SLOT_W'(BYTE_W);
    localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(BYTE_W + 1);

    frame_t f_d, f_q;
    logic   addr_ok;

    always_comb begin
        addr_ok = (f_q.shreg[7:1] == {ADDR_HI, a_sel_i}) && !f_q.shreg[0];
        f_d     = f_q;
        f_d.upd = 1'b0;
        if (stop_i) begin
            f_d.phase = PH_IDLE;
            f_d.slot  = '0;
            f_d.ack   = 1'b0;
            f_d.hs    = 1'b0;
        end else if (start_i) begin
            f_d.phase = PH_ADDR;
            f_d.slot  = '0;
            f_d.ack   = 1'b0;
        end else if (f_q.phase != PH_IDLE) begin
            if (rise_i && f_q.slot < ACK_SLOT) begin
                if (f_q.slot < LAST_BIT)
                    f_d.shreg = {f_q.shreg[BYTE_W-2:0], sda_s};
                f_d.slot = f_q.slot + 1'b1;
            end
            if (fall_i && f_q.slot == LAST_BIT) begin
                unique case (f_q.phase)
                    PH_ADDR: begin
                        if (f_q.shreg[7:3] == MCODE) f_d.hs  = 1'b1;
                        else                         f_d.ack = addr_ok;
                    end
                    PH_CTRL: begin
                        f_d.ack       = 1'b1;
                        f_d.ctrl_pend = f_q.shreg;
                    end
                    PH_HIGH: begin
                        f_d.ack = 1'b1;
                        f_d.hi  = f_q.shreg;
                    end
                    PH_LOW:  f_d.ack = 1'b1;
                    default: f_d.ack = 1'b0;
                endcase
            end else if (fall_i && f_q.slot == ACK_SLOT) begin
                f_d.slot = '0;
                f_d.ack  = 1'b0;
                unique case (f_q.phase)
                    PH_ADDR: f_d.phase = f_q.ack ? PH_CTRL : PH_SKIP;
                    PH_CTRL: f_d.phase = PH_HIGH;
                    PH_HIGH: f_d.phase = PH_LOW;
                    PH_LOW: begin
                        f_d.phase = PH_HIGH;
                        f_d.word  = {f_q.hi, f_q.shreg};
                        f_d.ctrl  = f_q.ctrl_pend;
                        f_d.upd   = 1'b1;
                    end
                    default: f_d.phase = PH_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign ack_o  = f_q.ack;
    assign hs_o   = f_q.hs;
    assign word_o = f_q.word;
    assign ctrl_o = f_q.ctrl;
    assign upd_o  = f_q.upd;
endmodule

// File: rtl/dac_word_i2c_rx.sv
module dac_word_i2c_rx #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b100110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    input  logic        a_sel_i,
    output logic        sda_pull_o,
    output logic [15:0] word_o,
    output logic [7:0]  ctrl_o,
    output logic        load_pulse_o,
    output logic        hs_active_o
);
    logic scl_s, sda_s;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    dacrx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .sync_o ({scl_s, sda_s})
    );

    dacrx_events u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    dacrx_frame #(.ADDR_HI(ADDR_HI)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ev_start),
        .stop_i  (ev_stop),
        .rise_i  (ev_rise),
        .fall_i  (ev_fall),
        .sda_s   (sda_s),
        .a_sel_i (a_sel_i),
        .ack_o   (sda_pull_o),
        .hs_o    (hs_active_o),
        .word_o  (word_o),
        .ctrl_o  (ctrl_o),
        .upd_o   (load_pulse_o)
    );
endmodule

// File: rtl/dacrx_checker.sv
module dacrx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_s,
    input logic        sda_pull_o,
    input logic [15:0] word_o,
    input logic [7:0]  ctrl_o,
    input logic        load_pulse_o,
    input logic        hs_active_o
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> !load_pulse_o); // R7

    AST_PULSE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_pulse_o) |-> $past(sda_pull_o)); // R6

    AST_PULSE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |-> !scl_s); // R7

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse_o |-> ($stable(word_o) && $stable(ctrl_o))); // R9

    AST_ACK_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s); // R2

    AST_MCODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active_o) |-> !sda_pull_o); // R3
endmodule

bind dac_word_i2c_rx dacrx_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_s        (scl_s),
    .sda_pull_o   (sda_pull_o),
    .word_o       (word_o),
    .ctrl_o       (ctrl_o),
    .load_pulse_o (load_pulse_o),
    .hs_active_o  (hs_active_o)
);

// File: tb/dac_word_i2c_rx_test.sv
module dac_word_i2c_rx_test;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, a_sel = 1'b0;
    logic sda_pull, load_pulse, hs_active;
    logic [15:0] word;
    logic [7:0]  ctrl;
    wire         sda_line = sda_m & ~sda_pull;

    int n_chk = 0, n_bad = 0, upd_n = 0, pulse_err = 0, upd_at_ack = 0;
    logic upd_prev = 1'b0;
    logic last_ack;

    always #2.5 clk = ~clk;

    dac_word_i2c_rx uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .a_sel_i(a_sel),
        .sda_pull_o(sda_pull), .word_o(word), .ctrl_o(ctrl),
        .load_pulse_o(load_pulse), .hs_active_o(hs_active)
    );

    always @(negedge clk) begin
        if (load_pulse) upd_n++;
        if (load_pulse && upd_prev) pulse_err++;
        upd_prev <= load_pulse;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; scl = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_restart();
        sda_m = 1'b1; hold();
        scl = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold();
        scl = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold();
            scl = 1'b1; hold();
            scl = 1'b0;
        end
        hold();
        sda_m = 1'b1; hold();
        scl = 1'b1;
        repeat (Q / 2) @(negedge clk);
        last_ack   = sda_pull;
        upd_at_ack = upd_n;
        repeat (Q / 2) @(negedge clk);
        scl = 1'b0; hold(); hold();
    endtask

    initial begin
        repeat (20000 * 10) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base;
        logic [15:0] w;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pull", sda_pull, 0);
        chk("R1 word", word, 0);
        chk("R1 ctrl", ctrl, 0);
        chk("R1 pulse", load_pulse, 0);
        chk("R1 hs", hs_active, 0);

        // basic write
        bus_start();
        put_byte(8'h98); chk("R2 addr ack", last_ack, 1);
        hold(); chk("R2 released", sda_pull, 0);
        put_byte(8'h10); chk("R6 ctrl ack", last_ack, 1);
        put_byte(8'hA5); chk("R6 high ack", last_ack, 1);
        base = upd_n;
        put_byte(8'h3C); chk("R6 low ack", last_ack, 1);
        chk("R7 no pulse before fall", upd_at_ack, base);
        chk("R7 one pulse", upd_n, base + 1);
        chk("R7 word", word, 16'hA53C);
        chk("R7 ctrl", ctrl, 8'h10);

        // streamed pairs
        for (int k = 1; k <= 4; k++) begin
            w = 16'(16'h1357 * k + 16'h0101);
            base = upd_n;
            put_byte(w[15:8]); put_byte(w[7:0]);
            chk("R8 pulse", upd_n, base + 1);
            chk("R8 word", word, w);
            chk("R8 ctrl", ctrl, 8'h10);
        end

        // lone high byte then stop
        base = upd_n;
        w = word;
        put_byte(8'hFF);
        bus_stop();
        chk("R9 no pulse", upd_n, base);
        chk("R9 word kept", word, w);
        chk("R9 ctrl kept", ctrl, 8'h10);

        // read bit set, then later bytes ignored
        bus_start();
        put_byte(8'h99); chk("R5 read nack", last_ack, 0);
        put_byte(8'h12); chk("R5 later nack", last_ack, 0);
        put_byte(8'h34); chk("R5 later nack2", last_ack, 0);
        bus_stop();
        chk("R5 word kept", word, w);

        // repeated start mid data phase
        base = upd_n;
        bus_start();
        put_byte(8'h98); put_byte(8'h20); put_byte(8'h11);
        bus_restart();
        put_byte(8'h42); chk("R10 restart mismatch nack", last_ack, 0);
        bus_restart();
        put_byte(8'h98); chk("R10 restart addr ack", last_ack, 1);
        chk("R10 no pulse", upd_n, base);
        put_byte(8'h30); put_byte(8'h44); put_byte(8'h55);
        chk("R10 word", word, 16'h4455);
        chk("R10 ctrl", ctrl, 8'h30);
        bus_stop();

        // master code then repeated start
        bus_start();
        put_byte(8'h0D); chk("R3 mcode nack", last_ack, 0);
        chk("R3 hs set", hs_active, 1);
        bus_restart();
        chk("R4 hs kept on restart", hs_active, 1);
        put_byte(8'h98); chk("R4 addr in hs", last_ack, 1);
        put_byte(8'h01); put_byte(8'hBE); put_byte(8'hEF);
        chk("R4 word in hs", word, 16'hBEEF);
        bus_stop();
        chk("R4 hs cleared", hs_active, 0);

        // first-byte sweep at both strap levels
        for (int s = 0; s < 2; s++) begin
            a_sel = s[0];
            hold();
            for (int b = 0; b < 256; b++) begin
                logic [7:0] bb;
                logic       exp_mc, exp_ack;
                bb      = 8'(b);
                exp_mc  = (bb[7:3] == 5'b00001);
                exp_ack = (bb[7:1] == {6'b100110, s[0]}) && !bb[0];
                bus_start();
                put_byte(bb);
                chk(s[0] ? "R11 sweep ack" : "R2 sweep ack", last_ack, exp_ack);
                chk(exp_mc ? "R3 sweep hs" : "R5 sweep hs", hs_active, exp_mc);
                bus_stop();
                chk("R4 sweep hs clear", hs_active, 0);
            end
        end

        n_chk++;
        if (pulse_err != 0) begin
            n_bad++;
            $display("FAIL R7 wide pulse actual=%h expected=%h", pulse_err, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule